// File: doc/BRIEF.md
# Video Timing Standard Classifier

This block watches a sliced, active-low sync stream that has already been brought into the system clock domain. From that stream it works out which of seven component video timings is arriving: 525-line interlaced, 625-line interlaced, 525-line progressive, 625-line progressive, 750-line progressive (720p), and 1125-line interlaced (1080i) at either 60 Hz or 50 Hz. The result is reported on four static flags, plus a valid level that says the flags describe the signal now present.

The block counts system clocks between line-rate sync leading edges to measure the line period. Edges that fall well inside a line are treated as equalising or half-line pulses and are ignored. A sync pulse that stays low longer than a set threshold marks a vertical interval. The block counts the lines between vertical intervals. It recognises interlace when alternate vertical pulses sit half a line off the line grid. In that case the line counts of the two fields are added together to give the frame total.

The flags are updated only after the same standard has been seen for several frames in a row. If sync disappears, valid is cleared and the flags keep their last value.

Top module: `video_std_classifier`

## Requirements
- R1: After reset, `valid` is 0 and all four flags (`rate60`, `sdFlag`, `hdFlag`, `lineFam`) are 0.
- R2: When locked, `rate60` is 1 for the 60 Hz standards (525i, 525p, 720p, 1080i/60) and 0 for the 50 Hz standards (625i, 625p, 1080i/50).
- R3: When locked, `sdFlag` is 1 only for 525i and 625i. It is 0 for 525p, 625p and every high-definition standard.
- R4: When locked, `hdFlag` is 1 only for 720p, 1080i/60 and 1080i/50.
- R5: When locked, `lineFam` is 1 for 625i, 625p, 1080i/60 and 1080i/50, and 0 for 525i, 525p and 720p.
- R6: A sync pulse held low for `VERT_CLKS` clocks marks a vertical interval. The lines per frame are the accepted line edges between two vertical intervals. When consecutive vertical pulses alternate between starting on a line edge and starting half a line off it, the stream is interlaced. The frame total is then the sum of the two field counts, and each frame is evaluated at the vertical pulse that starts on a line edge.
- R7: A falling edge is counted as a line edge only if it arrives between 0.75 and 1.25 of the current line period after the previous accepted edge. Half-line pulses outside that window do not change the line count.
- R8: For an 1125-line interlaced frame, the line period in clocks selects the rate. A period below `HD_RATE_SPLIT` gives 1080i/60, and any other period gives 1080i/50.
- R9: The flags take the new standard, and `valid` rises, at the `LOCK_FRAMES`-th consecutive identical classification and not earlier. The line totals recognised are `LINES_SD60`, `LINES_SD50`, `LINES_HD_P` (progressive only) and `LINES_HD_I` (interlaced only).
- R10: If a locked stream produces a frame that classifies differently, `valid` drops at that frame's evaluation. The flags keep the old standard until the new one has been seen `LOCK_FRAMES` times.
- R11: A frame whose line total matches none of the recognised standards never sets `valid`.
- R12: If no line edge is accepted for `LOS_CLKS` clocks, `valid` falls to 0, the flags keep their last value, and measurement starts over from the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncN | input | 1 | Sliced sync, low during sync tips, synchronous to clk |
| rate60 | output | 1 | 1 = 60 Hz family, 0 = 50 Hz family |
| sdFlag | output | 1 | 1 = interlaced standard definition |
| hdFlag | output | 1 | 1 = high definition |
| lineFam | output | 1 | 1 = 625-line or 1125-line family |
| valid | output | 1 | 1 = flags describe the present locked standard |

## Verification
Two things happen in the same clock cycle on the falling edge that opens a vertical pulse: the edge is judged against the line-period window, and that judgement is latched as the pulse's grid phase. When the pulse falls half a line off the grid, the same cycle both rejects the edge as a line and marks the field as offset. This overlap is provoked by interlaced streams that also carry equalising pulses on early lines. It is judged by the frame totals coming out right, which shows up as the expected flags appearing exactly at the third frame. A second overlap is also exercised: a frame evaluation that both changes the candidate and clears `valid` while the flags stay put. This is provoked by switching seamlessly from a locked 525p stream to a 625p stream.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

  typedef enum logic [2:0] {
    STD_NONE,
    STD_525I,
    STD_625I,
    STD_525P,
    STD_625P,
    STD_720P,
    STD_1080I60,
    STD_1080I50
  } stdCode_t;

  // Ordered as the output pins: rate, sd, hd, family.
  typedef struct packed {
    logic rate60;
    logic sdFlag;
    logic hdFlag;
    logic lineFam;
  } flags_t;

  // One-cycle events from the field counter to the lock controller.
  typedef struct packed {
    logic evalStb;
    logic lossStb;
    logic interlaced;
  } strobe_t;

  function automatic flags_t encodeStd(stdCode_t code);
    flags_t f;
    case (code)
      STD_525I:    f = flags_t'(4'b1100);
      STD_625I:    f = flags_t'(4'b0101);
      STD_525P:    f = flags_t'(4'b1000);
      STD_625P:    f = flags_t'(4'b0001);
      STD_720P:    f = flags_t'(4'b1010);
      STD_1080I60: f = flags_t'(4'b1011);
      STD_1080I50: f = flags_t'(4'b0011);
      default:     f = flags_t'(4'b0000);
    endcase
    return f;
  endfunction

endpackage

// File: rtl/vsc_line_meter.sv
module vsc_line_meter #(
  parameter int LOS_CLKS  = 8192,
  parameter int REJ_LIMIT = 4,
  parameter int CNT_W     = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncN,
  output logic             fallEdge,
  output logic             lineEdge,
  output logic             lossStb,
  output logic [CNT_W-1:0] linePeriod
);

  localparam int REJ_W = $clog2(REJ_LIMIT + 1);
  localparam int EXT_W = CNT_W + 3;

  logic             syncPrev;
  logic             haveEdge;
  logic             perValid;
  logic [CNT_W-1:0] sinceAcc;
  logic [CNT_W-1:0] period;
  logic [REJ_W-1:0] rejCnt;
  logic [EXT_W-1:0] scaledGap;
  logic [EXT_W-1:0] lowBound;
  logic [EXT_W-1:0] highBound;
  logic             inWindow;
  logic             overLong;
  logic             relearn;
  logic             accept;

  assign fallEdge  = syncPrev & ~syncN;
  assign scaledGap = {1'b0, sinceAcc, 2'b00};
  assign lowBound  = {2'b00, period, 1'b0} + {3'b000, period};
  assign highBound = {1'b0, period, 2'b00} + {3'b000, period};
  assign inWindow  = (scaledGap >= lowBound) && (scaledGap <= highBound);
  assign overLong  = scaledGap > highBound;
  assign relearn   = rejCnt == REJ_W'(REJ_LIMIT - 1);
  assign accept    = fallEdge && (!haveEdge || !perValid || inWindow || overLong || relearn);
  assign lineEdge  = accept;
  assign lossStb   = haveEdge && !fallEdge && (sinceAcc >= CNT_W'(LOS_CLKS));
  assign linePeriod = period;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPrev <= 1'b1;
      haveEdge <= 1'b0;
      perValid <= 1'b0;
      sinceAcc <= '0;
      period   <= '0;
      rejCnt   <= '0;
    end else begin
      syncPrev <= syncN;
      if (accept) begin
        haveEdge <= 1'b1;
        sinceAcc <= CNT_W'(1);
        rejCnt   <= '0;
        if (haveEdge) begin
          period   <= sinceAcc;
          perValid <= 1'b1;
        end
      end else if (lossStb) begin
        haveEdge <= 1'b0;
        perValid <= 1'b0;
        rejCnt   <= '0;
      end else begin
        if (haveEdge && (sinceAcc < CNT_W'(LOS_CLKS))) sinceAcc <= sinceAcc + CNT_W'(1);
        if (fallEdge) rejCnt <= rejCnt + REJ_W'(1);
      end
    end
  end

endmodule

// File: rtl/vsc_field_counter.sv
module vsc_field_counter #(
  parameter int VERT_CLKS = 250,
  parameter int LINE_W    = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 syncN,
  input  logic                 fallEdge,
  input  logic                 lineEdge,
  input  logic                 lossIn,
  output vsc_pkg::strobe_t     strb,
  output logic [LINE_W-1:0]    frameLines
);

  localparam int LOW_W = $clog2(VERT_CLKS + 1);

  logic [LOW_W-1:0]  lowCnt;
  logic              vertHit;
  logic              pulseOnLine;
  logic              prevOnLine;
  logic [LINE_W-1:0] lineCnt;
  logic [LINE_W-1:0] prevField;
  logic [1:0]        vertSeen;
  logic              interl;
  logic [LINE_W-1:0] lineSum;
  logic              evalOk;

  assign vertHit = !syncN && (lowCnt == LOW_W'(VERT_CLKS - 1));
  assign interl  = !prevOnLine;
  assign lineSum = interl ? (prevField + lineCnt) : lineCnt;
  assign evalOk  = vertHit && pulseOnLine && (vertSeen != 2'd0) && (!interl || vertSeen == 2'd2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt      <= '0;
      pulseOnLine <= 1'b0;
      prevOnLine  <= 1'b1;
      lineCnt     <= '0;
      prevField   <= '0;
      vertSeen    <= 2'd0;
      strb        <= '0;
      frameLines  <= '0;
    end else begin
      strb.evalStb <= 1'b0;
      strb.lossStb <= lossIn;

      if (syncN) lowCnt <= '0;
      else if (lowCnt < LOW_W'(VERT_CLKS)) lowCnt <= lowCnt + LOW_W'(1);

      if (fallEdge) pulseOnLine <= lineEdge;

      if (lossIn) begin
        vertSeen   <= 2'd0;
        lineCnt    <= '0;
        prevOnLine <= 1'b1;
      end else if (vertHit) begin
        strb.evalStb    <= evalOk;
        strb.interlaced <= interl;
        frameLines      <= lineSum;
        prevField       <= lineCnt;
        prevOnLine      <= pulseOnLine;
        lineCnt         <= '0;
        if (vertSeen != 2'd2) vertSeen <= vertSeen + 2'd1;
      end else if (lineEdge && (lineCnt != '1)) begin
        lineCnt <= lineCnt + LINE_W'(1);
      end
    end
  end

endmodule

// File: rtl/vsc_lock_ctl.sv
module vsc_lock_ctl #(
  parameter int LINES_SD60    = 525,
  parameter int LINES_SD50    = 625,
  parameter int LINES_HD_P    = 750,
  parameter int LINES_HD_I    = 1125,
  parameter int HD_RATE_SPLIT = 880,
  parameter int LOCK_FRAMES   = 3,
  parameter int LINE_W        = 12,
  parameter int CNT_W         = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  vsc_pkg::strobe_t   strb,
  input  logic [LINE_W-1:0]  frameLines,
  input  logic [CNT_W-1:0]   linePeriod,
  output vsc_pkg::flags_t    flags,
  output logic               valid
);
  import vsc_pkg::*;

  localparam int MC_W = $clog2(LOCK_FRAMES + 1);

  stdCode_t       cls;
  stdCode_t       cand;
  logic [MC_W-1:0] matchCnt;
  logic [MC_W-1:0] nextCnt;
  logic            lockNow;

  always_comb begin
    cls = STD_NONE;
    if (frameLines == LINE_W'(LINES_SD60)) begin
      cls = strb.interlaced ? STD_525I : STD_525P;
    end else if (frameLines == LINE_W'(LINES_SD50)) begin
      cls = strb.interlaced ? STD_625I : STD_625P;
    end else if (frameLines == LINE_W'(LINES_HD_P) && !strb.interlaced) begin
      cls = STD_720P;
    end else if (frameLines == LINE_W'(LINES_HD_I) && strb.interlaced) begin
      cls = (linePeriod < CNT_W'(HD_RATE_SPLIT)) ? STD_1080I60 : STD_1080I50;
    end
  end

  always_comb begin
    if (cls != cand) nextCnt = MC_W'(1);
    else if (matchCnt == MC_W'(LOCK_FRAMES)) nextCnt = matchCnt;
    else nextCnt = matchCnt + MC_W'(1);
  end

  assign lockNow = (cls != STD_NONE) && (nextCnt == MC_W'(LOCK_FRAMES));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cand     <= STD_NONE;
      matchCnt <= '0;
      valid    <= 1'b0;
      flags    <= '0;
    end else if (strb.lossStb) begin
      cand     <= STD_NONE;
      matchCnt <= '0;
      valid    <= 1'b0;
    end else if (strb.evalStb) begin
      cand     <= cls;
      matchCnt <= nextCnt;
      valid    <= lockNow;
      if (lockNow) flags <= encodeStd(cls);
    end
  end

endmodule

// File: rtl/video_std_classifier.sv
module video_std_classifier #(
  parameter int LINES_SD60    = 525,
  parameter int LINES_SD50    = 625,
  parameter int LINES_HD_P    = 750,
  parameter int LINES_HD_I    = 1125,
  parameter int HD_RATE_SPLIT = 880,
  parameter int VERT_CLKS     = 250,
  parameter int LOS_CLKS      = 8192,
  parameter int REJ_LIMIT     = 4,
  parameter int LOCK_FRAMES   = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic syncN,
  output logic rate60,
  output logic sdFlag,
  output logic hdFlag,
  output logic lineFam,
  output logic valid
);

  localparam int CNT_W  = $clog2(LOS_CLKS + 1);
  localparam int LINE_W = $clog2(2 * LINES_HD_I + 2);

  logic               fallEdge;
  logic               lineEdge;
  logic               lossStb;
  logic [CNT_W-1:0]   linePeriod;
  logic [LINE_W-1:0]  frameLines;
  vsc_pkg::strobe_t   fieldStrb;
  vsc_pkg::flags_t    flagsQ;

  vsc_line_meter #(
    .LOS_CLKS(LOS_CLKS), .REJ_LIMIT(REJ_LIMIT), .CNT_W(CNT_W)
  ) meter_i (
    .clk(clk), .rstN(rstN), .syncN(syncN),
    .fallEdge(fallEdge), .lineEdge(lineEdge), .lossStb(lossStb),
    .linePeriod(linePeriod)
  );

  vsc_field_counter #(
    .VERT_CLKS(VERT_CLKS), .LINE_W(LINE_W)
  ) field_i (
    .clk(clk), .rstN(rstN), .syncN(syncN),
    .fallEdge(fallEdge), .lineEdge(lineEdge), .lossIn(lossStb),
    .strb(fieldStrb), .frameLines(frameLines)
  );

  vsc_lock_ctl #(
    .LINES_SD60(LINES_SD60), .LINES_SD50(LINES_SD50),
    .LINES_HD_P(LINES_HD_P), .LINES_HD_I(LINES_HD_I),
    .HD_RATE_SPLIT(HD_RATE_SPLIT), .LOCK_FRAMES(LOCK_FRAMES),
    .LINE_W(LINE_W), .CNT_W(CNT_W)
  ) lock_i (
    .clk(clk), .rstN(rstN), .strb(fieldStrb),
    .frameLines(frameLines), .linePeriod(linePeriod),
    .flags(flagsQ), .valid(valid)
  );

  assign rate60  = flagsQ.rate60;
  assign sdFlag  = flagsQ.sdFlag;
  assign hdFlag  = flagsQ.hdFlag;
  assign lineFam = flagsQ.lineFam;

endmodule

// File: rtl/vsc_checker.sv
module vsc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       evalStb,
  input logic       lossStb,
  input logic [3:0] flagBus,
  input logic       valid
);

  // R9: flags move only together with a fresh lock
  a_r9_flags_move_on_lock: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(flagBus) |-> $rose(valid));

  // R9: valid rises only after a frame evaluation
  a_r9_valid_after_eval: assert property (@(posedge clk) disable iff (!rstN)
    $rose(valid) |-> $past(evalStb));

  // R12: loss of sync clears valid
  a_r12_loss_clears_valid: assert property (@(posedge clk) disable iff (!rstN)
    lossStb |=> !valid);

  // R3 and R4: never both interlaced-SD and HD
  a_r3_sd_hd_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(flagBus[2] && flagBus[1]));

  // R2: HD outside the 1125 family is 720p, a 60 Hz standard
  a_r2_hd_short_family_rate: assert property (@(posedge clk) disable iff (!rstN)
    (flagBus[1] && !flagBus[0]) |-> flagBus[3]);

endmodule

bind video_std_classifier vsc_checker chk_i (
  .clk(clk), .rstN(rstN),
  .evalStb(fieldStrb.evalStb), .lossStb(fieldStrb.lossStb),
  .flagBus({rate60, sdFlag, hdFlag, lineFam}), .valid(valid)
);

// File: tb/video_std_classifier_tb.sv
module video_std_classifier_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_A = 11;
  localparam int N_B = 13;
  localparam int N_C = 15;
  localparam int N_D = 17;
  localparam int SPLIT = 35;
  localparam int VCLK = 8;
  localparam int LOSS = 200;
  localparam int HW = 3;
  localparam int VW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncN = 1'b1;
  logic rate60, sdFlag, hdFlag, lineFam, valid;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  video_std_classifier #(
    .LINES_SD60(N_A), .LINES_SD50(N_B), .LINES_HD_P(N_C), .LINES_HD_I(N_D),
    .HD_RATE_SPLIT(SPLIT), .VERT_CLKS(VCLK), .LOS_CLKS(LOSS),
    .REJ_LIMIT(4), .LOCK_FRAMES(3)
  ) dut_i (
    .clk(clk), .rstN(rstN), .syncN(syncN),
    .rate60(rate60), .sdFlag(sdFlag), .hdFlag(hdFlag), .lineFam(lineFam),
    .valid(valid)
  );

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expFlags(int n, bit il, int t);
    logic r, s, h, f;
    r = (n == N_A) || (n == N_C) || (n == N_D && t < SPLIT);
    s = il && (n != N_D);
    h = (n == N_C) || (n == N_D);
    f = (n == N_B) || (n == N_D);
    return {r, s, h, f};
  endfunction

  task automatic driveLine(int t, int w1, int mid);
    for (int c = 0; c < t; c++) begin
      @(negedge clk);
      if (c < w1) syncN = 1'b0;
      else if (mid > 0 && c >= t / 2 && c < t / 2 + mid) syncN = 1'b0;
      else syncN = 1'b1;
    end
  endtask

  task automatic genFrames(int n, bit il, int t, int count);
    for (int f = 0; f < count; f++) begin
      for (int k = 0; k < n; k++) begin
        int mid;
        if (il && k == (n - 1) / 2) mid = VW;
        else if (k >= 1 && k <= 2) mid = HW;
        else mid = 0;
        driveLine(t, (k == 0) ? VW : HW, mid);
      end
    end
  endtask

  task automatic gap();
    for (int c = 0; c < LOSS + 20; c++) begin
      @(negedge clk);
      syncN = 1'b1;
    end
  endtask

  function automatic logic [3:0] flagsNow();
    return {rate60, sdFlag, hdFlag, lineFam};
  endfunction

  task automatic runStd(int n, bit il, int t, inout logic [3:0] held);
    logic [3:0] e;
    e = expFlags(n, il, t);
    genFrames(n, il, t, 3);
    check($sformatf("R9 no early valid n=%0d il=%0d", n, il), {3'b0, valid}, 4'b0);
    check($sformatf("R12 flags held before lock n=%0d", n), flagsNow(), held);
    driveLine(t, VW, 0);
    check($sformatf("R6 R7 R9 valid at third frame n=%0d il=%0d", n, il), {3'b0, valid}, 4'b1);
    check($sformatf("R2 R8 rate n=%0d t=%0d", n, t), {3'b0, rate60}, {3'b0, e[3]});
    check($sformatf("R3 sd n=%0d il=%0d", n, il), {3'b0, sdFlag}, {3'b0, e[2]});
    check($sformatf("R4 hd n=%0d", n), {3'b0, hdFlag}, {3'b0, e[1]});
    check($sformatf("R5 family n=%0d", n), {3'b0, lineFam}, {3'b0, e[0]});
    gap();
    check($sformatf("R12 valid low after loss n=%0d", n), {3'b0, valid}, 4'b0);
    check($sformatf("R12 flags held after loss n=%0d", n), flagsNow(), e);
    held = e;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] held;
    held = 4'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset valid", {3'b0, valid}, 4'b0);
    check("R1 reset flags", flagsNow(), 4'b0);

    runStd(N_A, 1'b1, 32, held);
    runStd(N_B, 1'b1, 32, held);
    runStd(N_A, 1'b0, 32, held);
    runStd(N_B, 1'b0, 32, held);
    runStd(N_C, 1'b0, 32, held);
    runStd(N_D, 1'b1, 32, held);
    runStd(N_D, 1'b1, 38, held);

    genFrames(12, 1'b0, 32, 5);
    driveLine(32, VW, 0);
    check("R11 unknown line total never valid", {3'b0, valid}, 4'b0);
    check("R11 flags untouched by unknown total", flagsNow(), held);
    gap();

    genFrames(N_A, 1'b0, 32, 4);
    check("R9 525p locked before switch", {3'b0, valid}, 4'b1);
    check("R9 525p flags before switch", flagsNow(), expFlags(N_A, 1'b0, 32));
    genFrames(N_B, 1'b0, 32, 2);
    check("R10 valid drops on differing frame", {3'b0, valid}, 4'b0);
    check("R10 flags held on differing frame", flagsNow(), expFlags(N_A, 1'b0, 32));
    genFrames(N_B, 1'b0, 32, 1);
    check("R10 no relock before third frame", {3'b0, valid}, 4'b0);
    driveLine(32, VW, 0);
    check("R10 relock valid", {3'b0, valid}, 4'b1);
    check("R10 relock flags", flagsNow(), expFlags(N_B, 1'b0, 32));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule